// File: doc/BRIEF.md
# Transceiver Reconfiguration Command Sequencer

This block sits between a simple command interface and a memory-mapped reconfiguration controller for a serial transceiver. A single start pulse with an opcode launches a fixed, ordered script of bus writes. Where the script needs it, the block waits on the controller's busy line or reads a value back. A one-cycle done pulse marks the end of the script.

Three scripts exist:
- A PLL switch streams a stored settings image to the controller. Its image base address is a parameter that defaults to 0x8000. When the new data rate is high enough, a duty-cycle calibration follows on its own.
- A manual duty-cycle calibration turns calibration on, waits while the controller reports busy, then turns it off.
- An output-swing update writes a 6-bit setting and reads it back for checking.

After each streamed image and after each completed calibration, the block pulses a channel reset request. A command that arrives while a script is running is refused with an error pulse. A busy wait that exceeds a programmable cycle limit aborts the script.

Top module: `xcvr_reconfig_sequencer`

## Requirements
- R1: Opcode 0 (PLL switch) issues eight writes in this exact order, as address←data: 0x38←0, 0x3A←0, 0x3B←0, 0x3C←IMAGE_BASE (default 0x8000), 0x3A←1, 0x3B←1, 0x3C←1, 0x3A←1. It then waits until ctrl_busy is low.
- R2: Opcode 1 (calibrate) issues 0x48←0, 0x4B←0 and 0x4C←1. It then waits while ctrl_busy is high, and only after that issues 0x4C←0.
- R3: Opcode 2 (swing) issues 0x08←0, 0x0B←0, 0x0C←swing and 0x0A←1, where swing is the 6-bit value 0 to 63. It then reads address 0x0C and presents bits [5:0] of the read data on swing_readback when done pulses.
- R4: After a PLL switch, the calibration script of R2 runs when cmd_rate_kbps is at least 4915200. For any lower rate it does not run.
- R5: chan_reset pulses for one cycle after each completed stream and after each completed calibration. A swing update never pulses it.
- R6: While av_waitrequest is high, an active write keeps av_write, av_address and av_writedata unchanged. The next step starts only after the write is accepted.
- R7: done is high for exactly one cycle at the end of every script, including an aborted one.
- R8: cmd_valid while a script runs raises err on the next cycle and does not alter the running script.
- R9: If ctrl_busy stays high for more than busy_limit polled cycles, the script aborts. err and done pulse together, and neither the calibration-off write nor a channel reset is issued.
- R10: Opcode 3 is refused: err pulses on the next cycle and no bus access takes place.
- R11: After reset, done, err, chan_reset, av_write and av_read are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start pulse for a command |
| cmd_op | input | 2 | Opcode: 0 PLL switch, 1 calibrate, 2 swing, 3 refused |
| cmd_rate_kbps | input | RATE_W | New data rate in kb/s for a PLL switch |
| cmd_swing | input | 6 | Output-swing setting |
| busy_limit | input | LIMIT_W | Busy-poll timeout in cycles |
| done | output | 1 | One-cycle end-of-script pulse |
| err | output | 1 | One-cycle refusal or timeout pulse |
| chan_reset | output | 1 | One-cycle channel reset request |
| swing_readback | output | 6 | Swing value read back by opcode 2 |
| av_address | output | 8 | Bus address |
| av_write | output | 1 | Bus write request |
| av_read | output | 1 | Bus read request |
| av_writedata | output | 32 | Bus write data |
| av_readdata | input | 32 | Bus read data |
| av_waitrequest | input | 1 | Slave stall |
| ctrl_busy | input | 1 | Controller busy indication |

## Verification
The assertions assume that the slave eventually drops av_waitrequest. They also assume that ctrl_busy rises only in response to a write the block has issued. The calibration-off write is asserted never to coincide with a high busy line, and that only holds if busy does not rise spontaneously. The bench model stalls every access for one cycle and raises busy solely after a calibration-on write or a control-strobe write. It also keeps busy_limit constant during a script, which the bounded-counter check in the timer relies on.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    localparam int ADDR_W        = 8;
    localparam int DATA_W        = 32;
    localparam int IDX_W         = 3;
    localparam int CAL_RATE_KBPS = 4915200;
    localparam logic [ADDR_W-1:0] SWING_RD_ADDR = 8'h0C;

    typedef enum logic [1:0] {
        OP_PLL_SWITCH = 2'd0,
        OP_CALIBRATE  = 2'd1,
        OP_SWING      = 2'd2,
        OP_NONE       = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_STREAM,
        PH_CAL,
        PH_SWING
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              poll;   // wait for busy low after this write
        logic              last;   // final write of the phase
    } step_t;

    function automatic step_t mk(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                                 logic p, logic l);
        step_t s;
        s.addr = a; s.data = d; s.poll = p; s.last = l;
        return s;
    endfunction

    function automatic step_t script_step(phase_e ph, logic [IDX_W-1:0] idx,
                                          logic [DATA_W-1:0] base,
                                          logic [5:0] swing);
        step_t s;
        s = '0;
        case (ph)
            PH_STREAM: case (idx)
                3'd0:    s = mk(8'h38, 32'd0, 1'b0, 1'b0);
                3'd1:    s = mk(8'h3A, 32'd0, 1'b0, 1'b0);
                3'd2:    s = mk(8'h3B, 32'd0, 1'b0, 1'b0);
                3'd3:    s = mk(8'h3C, base,  1'b0, 1'b0);
                3'd4:    s = mk(8'h3A, 32'd1, 1'b0, 1'b0);
                3'd5:    s = mk(8'h3B, 32'd1, 1'b0, 1'b0);
                3'd6:    s = mk(8'h3C, 32'd1, 1'b0, 1'b0);
                default: s = mk(8'h3A, 32'd1, 1'b1, 1'b1);
            endcase
            PH_CAL: case (idx)
                3'd0:    s = mk(8'h48, 32'd0, 1'b0, 1'b0);
                3'd1:    s = mk(8'h4B, 32'd0, 1'b0, 1'b0);
                3'd2:    s = mk(8'h4C, 32'd1, 1'b1, 1'b0);
                default: s = mk(8'h4C, 32'd0, 1'b0, 1'b1);
            endcase
            default: case (idx)
                3'd0:    s = mk(8'h08, 32'd0, 1'b0, 1'b0);
                3'd1:    s = mk(8'h0B, 32'd0, 1'b0, 1'b0);
                3'd2:    s = mk(8'h0C, {26'd0, swing}, 1'b0, 1'b0);
                default: s = mk(8'h0A, 32'd1, 1'b0, 1'b1);
            endcase
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xrs_rate_gate.sv
module xrs_rate_gate #(
    parameter int RATE_W = 32,
    parameter int THRESH = 4915200
) (
    input  logic [RATE_W-1:0] rate_kbps,
    output logic              need_cal
);
    localparam logic [RATE_W-1:0] TH = RATE_W'(THRESH);

    assign need_cal = (rate_kbps >= TH);
endmodule

// File: rtl/xrs_busy_timer.sv
module xrs_busy_timer #(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               run,
    input  logic [LIMIT_W-1:0] limit,
    output logic               expired
);
    logic [LIMIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (run && cnt != limit)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == limit);

    // R9: the poll counter never runs past the programmed limit
    assert_cnt_bounded_R9: assert property (@(posedge clk) disable iff (rst)
        !clear |-> cnt <= limit);
endmodule

// File: rtl/xcvr_reconfig_sequencer.sv
module xcvr_reconfig_sequencer
    import xrs_pkg::*;
#(
    parameter logic [DATA_W-1:0] IMAGE_BASE = 32'h0000_8000,
    parameter int RATE_W  = 32,
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [RATE_W-1:0]  cmd_rate_kbps,
    input  logic [5:0]         cmd_swing,
    input  logic [LIMIT_W-1:0] busy_limit,
    output logic               done,
    output logic               err,
    output logic               chan_reset,
    output logic [5:0]         swing_readback,
    output logic [ADDR_W-1:0]  av_address,
    output logic               av_write,
    output logic               av_read,
    output logic [DATA_W-1:0]  av_writedata,
    input  logic [DATA_W-1:0]  av_readdata,
    input  logic               av_waitrequest,
    input  logic               ctrl_busy
);
    typedef enum logic [2:0] {S_IDLE, S_WR, S_POLL, S_RD, S_RST, S_FIN} state_e;

    state_e           state;
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic [5:0]       swing_q;
    logic             cal_q;
    logic             need_cal;
    logic             expired;
    step_t            step;
    logic             unused_rd;

    assign unused_rd = ^av_readdata[DATA_W-1:6];

    xrs_rate_gate #(.RATE_W(RATE_W), .THRESH(CAL_RATE_KBPS)) u_gate (
        .rate_kbps (cmd_rate_kbps),
        .need_cal  (need_cal)
    );

    xrs_busy_timer #(.LIMIT_W(LIMIT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (state != S_POLL),
        .run     ((state == S_POLL) && ctrl_busy),
        .limit   (busy_limit),
        .expired (expired)
    );

    always_comb step = script_step(phase, idx, IMAGE_BASE, swing_q);

    assign av_write     = (state == S_WR);
    assign av_read      = (state == S_RD);
    assign av_address   = (state == S_RD) ? SWING_RD_ADDR : step.addr;
    assign av_writedata = step.data;
    assign chan_reset   = (state == S_RST);
    assign done         = (state == S_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= S_IDLE;
            phase          <= PH_STREAM;
            idx            <= '0;
            swing_q        <= '0;
            cal_q          <= 1'b0;
            err            <= 1'b0;
            swing_readback <= '0;
        end else begin
            err <= 1'b0;
            if (cmd_valid && (state != S_IDLE || cmd_op == OP_NONE))
                err <= 1'b1;
            case (state)
                S_IDLE: if (cmd_valid && cmd_op != OP_NONE) begin
                    idx     <= '0;
                    swing_q <= cmd_swing;
                    cal_q   <= need_cal;
                    case (cmd_op)
                        OP_PLL_SWITCH: phase <= PH_STREAM;
                        OP_CALIBRATE:  phase <= PH_CAL;
                        default:       phase <= PH_SWING;
                    endcase
                    state <= S_WR;
                end
                S_WR: if (!av_waitrequest) begin
                    if (step.poll)
                        state <= S_POLL;
                    else if (step.last)
                        state <= (phase == PH_SWING) ? S_RD : S_RST;
                    else
                        idx <= idx + 1'b1;
                end
                S_POLL: begin
                    if (expired) begin
                        err   <= 1'b1;
                        state <= S_FIN;
                    end else if (!ctrl_busy) begin
                        if (step.last) begin
                            state <= S_RST;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= S_WR;
                        end
                    end
                end
                S_RD: if (!av_waitrequest) begin
                    swing_readback <= av_readdata[5:0];
                    state          <= S_FIN;
                end
                S_RST: begin
                    if (phase == PH_STREAM && cal_q) begin
                        phase <= PH_CAL;
                        idx   <= '0;
                        state <= S_WR;
                    end else begin
                        state <= S_FIN;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R6: a stalled write holds its address and data
    assert_write_hold_R6: assert property (@(posedge clk) disable iff (rst)
        av_write && av_waitrequest |=> av_write && $stable(av_address) && $stable(av_writedata));

    // R7: done lasts one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a command during a running script is flagged
    assert_reject_busy_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && state != S_IDLE |=> err);

    // R2: calibration is switched off only once busy has dropped
    assert_cal_off_idle_R2: assert property (@(posedge clk) disable iff (rst)
        av_write && av_address == 8'h4C && av_writedata == 32'd0 |-> !ctrl_busy);

    // R5: a channel reset never overlaps bus traffic
    assert_reset_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        chan_reset |-> !ctrl_busy && !av_write && !av_read);
endmodule

// File: tb/test_xcvr_reconfig_sequencer.sv
`timescale 1ns/1ps
module test_xcvr_reconfig_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_rate_kbps = 32'd0;
    logic [5:0]  cmd_swing = 6'd0;
    logic [15:0] busy_limit = 16'd100;
    logic        done, err, chan_reset;
    logic [5:0]  swing_readback;
    logic [7:0]  av_address;
    logic        av_write, av_read;
    logic [31:0] av_writedata, av_readdata;
    logic        av_waitrequest;
    logic        ctrl_busy;

    always #2.5 clk = ~clk;

    xcvr_reconfig_sequencer i_xcvr_reconfig_sequencer (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rate_kbps(cmd_rate_kbps), .cmd_swing(cmd_swing), .busy_limit(busy_limit),
        .done(done), .err(err), .chan_reset(chan_reset), .swing_readback(swing_readback),
        .av_address(av_address), .av_write(av_write), .av_read(av_read),
        .av_writedata(av_writedata), .av_readdata(av_readdata),
        .av_waitrequest(av_waitrequest), .ctrl_busy(ctrl_busy)
    );

    // ---------------- slave model ----------------
    logic [31:0] regs [0:255];
    logic        ack = 1'b0;
    int          busy_cnt = 0;
    int          busy_len = 6;
    int          cyc = 0;
    int          n_wr = 0;
    int          n_rd = 0;
    int          n_rst = 0;
    logic [7:0]  log_a [0:31];
    logic [31:0] log_d [0:31];
    int          log_c [0:31];

    assign av_waitrequest = (av_write || av_read) && !ack;
    assign av_readdata    = regs[av_address];
    assign ctrl_busy      = (busy_cnt != 0);

    always @(posedge clk) begin
        cyc = cyc + 1;
        ack <= (av_write || av_read) && !ack;
        if (chan_reset) n_rst = n_rst + 1;
        if (av_read && !av_waitrequest) n_rd = n_rd + 1;
        if (av_write && !av_waitrequest) begin
            regs[av_address] <= av_writedata;
            if (n_wr < 32) begin
                log_a[n_wr] = av_address;
                log_d[n_wr] = av_writedata;
                log_c[n_wr] = cyc;
            end
            n_wr = n_wr + 1;
        end
        if (av_write && !av_waitrequest && av_address == 8'h4C && av_writedata == 32'd1)
            busy_cnt <= busy_len;
        else if (av_write && !av_waitrequest && av_address == 8'h3A && av_writedata == 32'd1)
            busy_cnt <= 3;
        else if (busy_cnt != 0)
            busy_cnt <= busy_cnt - 1;
    end

    // ---------------- checking ----------------
    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic got_err;

    task automatic run_cmd(input logic [1:0] op, input logic [31:0] rate, input logic [5:0] sw);
        int k;
        n_wr = 0; n_rd = 0; n_rst = 0; got_err = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_rate_kbps = rate; cmd_swing = sw;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (done) break;
        end
        chk("R7 done seen", {31'd0, done}, 32'd1);
        got_err = err;
        @(negedge clk);
        chk("R7 done one cycle", {31'd0, done}, 32'd0);
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] rate;
        logic [5:0]  sw;
        logic [7:0]  wr;
        logic [3:0]  rs;
        logic [3:0]  rd;
    } vec_t;

    localparam vec_t VEC [0:6] = '{
        '{2'd0, 32'd2500000, 6'd0,  8'd8,  4'd1, 4'd0},  // R4 low rate
        '{2'd0, 32'd5000000, 6'd0,  8'd12, 4'd2, 4'd0},  // R4 high rate
        '{2'd0, 32'd4915200, 6'd0,  8'd12, 4'd2, 4'd0},  // R4 threshold
        '{2'd0, 32'd4915199, 6'd0,  8'd8,  4'd1, 4'd0},  // R4 just below
        '{2'd1, 32'd0,       6'd0,  8'd4,  4'd1, 4'd0},  // R2 calibration
        '{2'd2, 32'd0,       6'd63, 8'd4,  4'd0, 4'd1},  // R3 max swing
        '{2'd2, 32'd0,       6'd21, 8'd4,  4'd0, 4'd1}   // R3 mid swing
    };

    localparam logic [7:0] STR_A [0:7] = '{8'h38, 8'h3A, 8'h3B, 8'h3C, 8'h3A, 8'h3B, 8'h3C, 8'h3A};
    localparam logic [31:0] STR_D [0:7] = '{0, 0, 0, 32'h8000, 1, 1, 1, 1};

    initial begin
        for (int i = 0; i < 256; i++) regs[i] = 32'd0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 done", {31'd0, done}, 0);
        chk("R11 err", {31'd0, err}, 0);
        chk("R11 chan_reset", {31'd0, chan_reset}, 0);
        chk("R11 bus idle", {30'd0, av_write, av_read}, 0);
        rst = 1'b0;

        for (int v = 0; v < 7; v++) begin
            run_cmd(VEC[v].op, VEC[v].rate, VEC[v].sw);
            chk("R4 write count", n_wr, {24'd0, VEC[v].wr});
            chk("R5 reset count", n_rst, {28'd0, VEC[v].rs});
            chk("R3 read count", n_rd, {28'd0, VEC[v].rd});
            chk("R9 no error", {31'd0, got_err}, 0);
            if (VEC[v].op == 2'd2)
                chk("R3 readback", {26'd0, swing_readback}, {26'd0, VEC[v].sw});
        end

        // R1: stream order
        run_cmd(2'd0, 32'd1000000, 6'd0);
        for (int i = 0; i < 8; i++) begin
            chk("R1 stream addr", {24'd0, log_a[i]}, {24'd0, STR_A[i]});
            chk("R1 stream data", log_d[i], STR_D[i]);
        end
        // R6: every write waited out one stall cycle
        chk("R6 stall spacing", log_c[1] - log_c[0], 2);

        // R2: calibration order and busy wait
        busy_len = 12;
        run_cmd(2'd1, 32'd0, 6'd0);
        chk("R2 on addr", {24'd0, log_a[2]}, 32'h4C);
        chk("R2 on data", log_d[2], 1);
        chk("R2 off addr", {24'd0, log_a[3]}, 32'h4C);
        chk("R2 off data", log_d[3], 0);
        chk("R2 waited for busy", {31'd0, (log_c[3] - log_c[2]) > 12}, 1);

        // R3: swing write order
        run_cmd(2'd2, 32'd0, 6'd42);
        chk("R3 addr0", {24'd0, log_a[0]}, 32'h08);
        chk("R3 addr1", {24'd0, log_a[1]}, 32'h0B);
        chk("R3 data2", log_d[2], 42);
        chk("R3 strobe", {24'd0, log_a[3]}, 32'h0A);

        // R9: timeout during calibration
        busy_len = 50; busy_limit = 16'd10;
        run_cmd(2'd1, 32'd0, 6'd0);
        chk("R9 err with done", {31'd0, got_err}, 1);
        chk("R9 writes", n_wr, 3);
        chk("R9 no reset", n_rst, 0);
        repeat (60) @(negedge clk);
        busy_len = 6; busy_limit = 16'd100;

        // R8: command during a running script
        n_wr = 0; n_rst = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_rate_kbps = 32'd2500000;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R8 err pulse", {31'd0, err}, 1);
        repeat (100) @(negedge clk);
        chk("R8 script unchanged", n_wr, 8);
        chk("R8 one reset", n_rst, 1);

        // R10: unused opcode
        n_wr = 0; n_rd = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10 err pulse", {31'd0, err}, 1);
        repeat (20) @(negedge clk);
        chk("R10 no bus access", n_wr + n_rd, 0);
        chk("R10 no done", {31'd0, done}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule